// File: doc/BRIEF.md
# Scheduled Differential-Equation Step Engine

This block advances a second-order differential equation by one fixed-point integration step for each accepted request. A producer offers the operands (position `x`, value `y`, derivative `u`, step size `dx`, and the bound `a`) on a valid/ready input. The block then runs a fixed schedule of eleven operations across four control steps. It produces the next `x`, `y` and `u`, together with a flag `c` that tells whether the new position is still below the bound.

Every operation has its own arithmetic unit and its own result register. A four-state Moore sequencer enables each result register only in the step assigned to it. The results are written to the output registers at the end of the fourth step, and `done` pulses once in the following cycle. An optional auto-iterate mode feeds the new `x`, `y` and `u` straight back and starts another pass while `c` is 1.

The input side follows the back-pressure rule below:
- `in_ready` is high only while the engine is idle.
- A transfer occurs on a clock edge where both `in_valid` and `in_ready` are high.
- While the engine is busy, a producer must hold its request.
- Requests offered while busy are not taken.

The results carry no back-pressure: they stay on the output pins until the next write-back.

Top module: `diffeq_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0, `in_ready` is 1, and `x_out`, `y_out`, `u_out` and `c_out` are 0.
- R2: `x_out` equals `x + dx`, taken as 16-bit two's complement with silent wrap.
- R3: `y_out` equals `y + u*dx`, keeping the low 16 bits of the product and wrapping.
- R4: `u_out` equals `u - (3*x)*(u*dx) - (3*y)*dx`, with every product and difference kept to its low 16 bits.
- R5: `c_out` is 1 exactly when the new `x` is less than `a` under a signed comparison. Equality gives 0.
- R6: `done` is high for exactly one cycle: the cycle that follows the fourth clock edge after the accepting edge. `busy` is high from the accepting edge until that pulse.
- R7: While `busy` is 1, `in_ready` is 0. An `in_valid` offered during that time has no effect on the results or on the number of `done` pulses.
- R8: The sequencer visits the steps in order 1, 2, 3, 4 at one step per clock. Each intermediate result register changes only in its own step.
- R9: With `auto_mode` high at the accepting edge, each pass that ends with `c` = 1 starts the next pass at step 1 with the new `x`, `y` and `u`, keeping `dx` and `a`. `busy` falls with the `done` of the first pass that ends with `c` = 0.
- R10: With `auto_mode` low at the accepting edge, exactly one pass runs and `busy` falls at the write-back edge.
- R11: `x_out`, `y_out`, `u_out` and `c_out` change only at a write-back edge, and hold their values in every cycle in which `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Engine idle, can take operands |
| auto_mode | input | 1 | Sampled on accept: repeat passes while `c` is 1 |
| x_in | input | 16 | Position, signed |
| y_in | input | 16 | Value, signed |
| u_in | input | 16 | Derivative, signed |
| dx_in | input | 16 | Step size, signed |
| a_in | input | 16 | Bound, signed |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse after each write-back |
| x_out | output | 16 | New position |
| y_out | output | 16 | New value |
| u_out | output | 16 | New derivative |
| c_out | output | 1 | New position below bound |

## Verification
Every result lands at the write-back edge, which is the fourth rising edge after the edge that accepted the operands. `done` and the four outputs can therefore be seen first in the cycle after that edge. The bench drives its inputs on falling edges and counts falling edges from the acceptance. It expects `done` low at the first four falling edges and high at the fifth, and it compares the outputs only at that point. In auto-iterate mode the same four-cycle window repeats. Each later pass is checked against a model advanced once per pass, and `busy` is checked at every pulse.

// File: rtl/diffeq_pkg.sv
package diffeq_pkg;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned NUM_STEPS = 4;

  typedef enum logic [1:0] {
    STEP1 = 2'd0,
    STEP2 = 2'd1,
    STEP3 = 2'd2,
    STEP4 = 2'd3
  } step_e;

  typedef logic [NUM_STEPS-1:0] step_en_t;
endpackage

// File: rtl/diffeq_mul.sv
// Dedicated signed multiplier, low-half product (wraps).
module diffeq_mul #(
  parameter int unsigned W = 16
) (
  input  logic signed [W-1:0] op_a,
  input  logic signed [W-1:0] op_b,
  output logic signed [W-1:0] prod
);
  logic signed [2*W-1:0] full;
  assign full = op_a * op_b;
  assign prod = full[W-1:0];
endmodule

// File: rtl/diffeq_ctrl.sv
// Four-state Moore sequencer with a run flag and an auto-repeat latch.
module diffeq_ctrl
  import diffeq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     accept,
  input  logic     auto_req,
  input  logic     cont,
  output logic     running,
  output step_en_t step_en,
  output logic     load_new,
  output logic     load_loop,
  output logic     writeback
);
  step_e step_q;
  logic  run_q;
  logic  auto_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      step_q <= STEP1;
      auto_q <= 1'b0;
    end else if (accept) begin
      run_q  <= 1'b1;
      step_q <= STEP1;
      auto_q <= auto_req;
    end else if (run_q) begin
      if (step_q == STEP4) begin
        step_q <= STEP1;
        run_q  <= auto_q && cont;
      end else begin
        step_q <= step_e'(step_q + 2'd1);
      end
    end
  end

  for (genvar s = 0; s < NUM_STEPS; s++) begin : g_step_dec
    assign step_en[s] = run_q && (step_q == step_e'(s));
  end

  assign running   = run_q;
  assign load_new  = accept;
  assign writeback = step_en[NUM_STEPS-1];
  assign load_loop = writeback && auto_q && cont;

  // R8
  step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && step_q != STEP4 && !accept) |=> (step_q == step_e'($past(step_q) + 2'd1)));
  // R8
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && step_q == STEP4 && auto_q && cont) |=> (run_q && step_q == STEP1));
  // R9
  auto_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && step_q == STEP4 && !(auto_q && cont)) |=> !run_q);
  // R8
  step_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_en));
endmodule

// File: rtl/diffeq_datapath.sv
// Dedicated-resource datapath: one unit and one register per scheduled operation.
module diffeq_datapath
  import diffeq_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_new,
  input  logic                load_loop,
  input  step_en_t            step_en,
  input  logic                writeback,
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] y_i,
  input  logic signed [W-1:0] u_i,
  input  logic signed [W-1:0] dx_i,
  input  logic signed [W-1:0] a_i,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o,
  output logic signed [W-1:0] u_o,
  output logic                c_o,
  output logic                cont
);
  localparam logic signed [W-1:0] THREE = W'(3);

  logic signed [W-1:0] xr, yr, ur, dxr, ar;
  // step 1 results
  logic signed [W-1:0] m3x_q, mudx_q, m3y_q, mudy_q, xnew_q;
  // step 2 results
  logic signed [W-1:0] t1_q, t2_q, ynew_q;
  logic                lt_q;
  // step 3 result
  logic signed [W-1:0] d1_q;

  logic signed [W-1:0] m3x_d, mudx_d, m3y_d, mudy_d, t1_d, t2_d, unew_d;

  diffeq_mul #(.W(W)) i_mul_3x  (.op_a(THREE),  .op_b(xr),     .prod(m3x_d));
  diffeq_mul #(.W(W)) i_mul_udx (.op_a(ur),     .op_b(dxr),    .prod(mudx_d));
  diffeq_mul #(.W(W)) i_mul_3y  (.op_a(THREE),  .op_b(yr),     .prod(m3y_d));
  diffeq_mul #(.W(W)) i_mul_udy (.op_a(ur),     .op_b(dxr),    .prod(mudy_d));
  diffeq_mul #(.W(W)) i_mul_t1  (.op_a(m3x_q),  .op_b(mudx_q), .prod(t1_d));
  diffeq_mul #(.W(W)) i_mul_t2  (.op_a(m3y_q),  .op_b(dxr),    .prod(t2_d));

  assign unew_d = d1_q - t2_q;
  assign cont   = lt_q;

  // operand registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xr <= '0; yr <= '0; ur <= '0; dxr <= '0; ar <= '0;
    end else if (load_new) begin
      xr <= x_i; yr <= y_i; ur <= u_i; dxr <= dx_i; ar <= a_i;
    end else if (load_loop) begin
      xr <= xnew_q; yr <= ynew_q; ur <= unew_d;
    end
  end

  // step 1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m3x_q <= '0; mudx_q <= '0; m3y_q <= '0; mudy_q <= '0; xnew_q <= '0;
    end else if (step_en[0]) begin
      m3x_q  <= m3x_d;
      mudx_q <= mudx_d;
      m3y_q  <= m3y_d;
      mudy_q <= mudy_d;
      xnew_q <= xr + dxr;
    end
  end

  // step 2
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t1_q <= '0; t2_q <= '0; ynew_q <= '0; lt_q <= 1'b0;
    end else if (step_en[1]) begin
      t1_q   <= t1_d;
      t2_q   <= t2_d;
      ynew_q <= yr + mudy_q;
      lt_q   <= xnew_q < ar;
    end
  end

  // step 3
  always_ff @(posedge clk) begin
    if (!rst_n)          d1_q <= '0;
    else if (step_en[2]) d1_q <= ur - t1_q;
  end

  // step 4: write-back
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_o <= '0; y_o <= '0; u_o <= '0; c_o <= 1'b0;
    end else if (writeback) begin
      x_o <= xnew_q;
      y_o <= ynew_q;
      u_o <= unew_d;
      c_o <= lt_q;
    end
  end

  // R8
  s1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en[0] |=> $stable({m3x_q, mudx_q, m3y_q, mudy_q, xnew_q}));
  // R8
  s2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en[1] |=> $stable({t1_q, t2_q, ynew_q, lt_q}));
  // R8
  s3_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en[2] |=> $stable(d1_q));
  // R7
  operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_new || load_loop) |=> $stable({xr, yr, ur, dxr, ar}));
endmodule

// File: rtl/diffeq_engine.sv
module diffeq_engine
  import diffeq_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                auto_mode,
  input  logic signed [W-1:0] x_in,
  input  logic signed [W-1:0] y_in,
  input  logic signed [W-1:0] u_in,
  input  logic signed [W-1:0] dx_in,
  input  logic signed [W-1:0] a_in,
  output logic                busy,
  output logic                done,
  output logic signed [W-1:0] x_out,
  output logic signed [W-1:0] y_out,
  output logic signed [W-1:0] u_out,
  output logic                c_out
);
  logic     running, accept, load_new, load_loop, writeback, cont;
  step_en_t step_en;
  logic     done_q;

  assign in_ready = !running;
  assign busy     = running;
  assign accept   = in_valid && !running;

  diffeq_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept), .auto_req(auto_mode),
    .cont(cont), .running(running), .step_en(step_en),
    .load_new(load_new), .load_loop(load_loop), .writeback(writeback)
  );

  diffeq_datapath #(.W(W)) i_dp (
    .clk(clk), .rst_n(rst_n), .load_new(load_new), .load_loop(load_loop),
    .step_en(step_en), .writeback(writeback),
    .x_i(x_in), .y_i(y_in), .u_i(u_in), .dx_i(dx_in), .a_i(a_in),
    .x_o(x_out), .y_o(y_out), .u_o(u_out), .c_o(c_out), .cont(cont)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= writeback;
  end
  assign done = done_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({x_out, y_out, u_out, c_out}));
  // R10
  single_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !auto_mode) |=> ##3 (busy ##1 !busy));
endmodule

// File: tb/test_diffeq_engine.sv
`timescale 1ns/1ps
module test_diffeq_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, auto_mode = 1'b0;
  logic signed [15:0] x_in = '0, y_in = '0, u_in = '0, dx_in = '0, a_in = '0;
  logic in_ready, busy, done, c_out;
  logic signed [15:0] x_out, y_out, u_out;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  diffeq_engine i_diffeq_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .auto_mode(auto_mode), .x_in(x_in), .y_in(y_in), .u_in(u_in),
    .dx_in(dx_in), .a_in(a_in), .busy(busy), .done(done),
    .x_out(x_out), .y_out(y_out), .u_out(u_out), .c_out(c_out)
  );

  // {x, y, u, dx, a}
  localparam logic [79:0] VEC [8] = '{
    {16'sd1,      16'sd2,      16'sd3,      16'sd1,    16'sd5},
    {-16'sd4,     16'sd7,      -16'sd2,     16'sd3,    16'sd0},
    {16'sd32767,  16'sd0,      16'sd0,      16'sd1,    16'sd0},
    {16'sd10,     -16'sd10,    16'sd100,    -16'sd7,   16'sd3},
    {16'sd200,    16'sd300,    16'sd400,    16'sd500,  -16'sd1},
    {16'sd5,      16'sd5,      16'sd5,      16'sd0,    16'sd5},
    {16'h8000,    16'h8000,    16'h8000,    -16'sd1,   16'sd32767},
    {16'sd0,      16'sd1,      -16'sd1,     16'sd2,    16'sd1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  // reference step built from the requirement formulas
  task automatic model(input logic [79:0] v, output logic signed [15:0] nx, ny, nu,
                       output logic nc);
    logic signed [15:0] x, y, u, dx, a, p;
    {x, y, u, dx, a} = v;
    nx = x + dx;
    p  = u * dx;
    ny = y + p;
    nu = u - (16'sd3 * x) * p - (16'sd3 * y) * dx;
    nc = nx < a;
  endtask

  task automatic check_out(input logic [79:0] v, input string ctx);
    logic signed [15:0] ex, ey, eu;
    logic ec;
    model(v, ex, ey, eu, ec);
    chk(x_out == ex, {"R2 x ", ctx}, x_out, ex);
    chk(y_out == ey, {"R3 y ", ctx}, y_out, ey);
    chk(u_out == eu, {"R4 u ", ctx}, u_out, eu);
    chk(c_out == ec, {"R5 c ", ctx}, c_out, ec);
  endtask

  // returns at the falling edge after the accepting edge
  task automatic launch(input logic [79:0] v, input logic au);
    @(negedge clk);
    chk(in_ready == 1'b1, "R7 ready idle", in_ready, 1);
    in_valid = 1'b1; auto_mode = au;
    {x_in, y_in, u_in, dx_in, a_in} = v;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; auto_mode = 1'b0;
  endtask

  // from the falling edge after accept (or after a write-back), to the next done cycle
  task automatic wait_pass(input string ctx);
    chk(done == 1'b0, {"R6 early ", ctx}, done, 0);
    chk(busy == 1'b1, {"R6 busy ", ctx}, busy, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(done == 1'b0, {"R6 early ", ctx}, done, 0);
    end
    @(negedge clk);
    chk(done == 1'b1, {"R6 due ", ctx}, done, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [79:0] cur;
    logic signed [15:0] hx, hy, hu;
    logic hc;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1
    chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
    chk(in_ready == 1, "R1 ready", in_ready, 1);
    chk(x_out == 0 && y_out == 0 && u_out == 0 && c_out == 0, "R1 outputs",
        x_out, 0);

    // table walk, single pass each
    foreach (VEC[k]) begin
      launch(VEC[k], 1'b0);
      wait_pass($sformatf("vec%0d", k));
      check_out(VEC[k], $sformatf("vec%0d", k));
      chk(busy == 0, "R10 idle after pass", busy, 0);
      @(negedge clk);
      chk(done == 0, "R6 one-cycle pulse", done, 1);
    end

    // R11: outputs hold while idle
    hx = x_out; hy = y_out; hu = u_out; hc = c_out;
    repeat (3) @(negedge clk);
    chk(x_out == hx && y_out == hy && u_out == hu && c_out == hc, "R11 hold",
        x_out, hx);

    // R7: offer while busy is ignored
    launch(VEC[0], 1'b0);
    in_valid = 1'b1; {x_in, y_in, u_in, dx_in, a_in} = VEC[3];
    @(negedge clk);
    chk(in_ready == 0, "R7 ready low while busy", in_ready, 0);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(done == 1, "R7 done timing", done, 1);
    check_out(VEC[0], "R7 ignored offer");
    @(negedge clk);
    chk(busy == 0 && done == 0, "R7 no extra pass", {busy, done}, 0);
    @(negedge clk);
    chk(busy == 0, "R10 stays idle", busy, 0);

    // R9: auto-iterate, x = 0 step 1 bound 3 -> three passes
    cur = {16'sd0, 16'sd1, 16'sd1, 16'sd1, 16'sd3};
    launch(cur, 1'b1);
    for (int p = 0; p < 3; p++) begin
      wait_pass($sformatf("R9 pass%0d", p));
      check_out(cur, $sformatf("R9 pass%0d", p));
      model(cur, hx, hy, hu, hc);
      chk(busy == hc, "R9 busy vs c", busy, hc);
      cur = {hx, hy, hu, cur[31:0]};
      if (p < 2) begin
        @(negedge clk);
        chk(busy == 1 && done == 0, "R9 next pass", {busy, done}, 2);
        // re-align: wait_pass expects to start one cycle into the pass
      end
      if (p < 2) begin
        for (int i = 0; i < 2; i++) begin
          @(negedge clk);
          chk(done == 0, "R9 mid pass", done, 0);
        end
        @(negedge clk);
        chk(done == 1, "R9 done due", done, 1);
        check_out(cur, $sformatf("R9 pass%0d", p + 1));
        model(cur, hx, hy, hu, hc);
        chk(busy == hc, "R9 busy vs c", busy, hc);
        cur = {hx, hy, hu, cur[31:0]};
        if (!hc) break;
        @(negedge clk);
        chk(done == 0, "R9 pulse width", done, 0);
        for (int i = 0; i < 2; i++) begin
          @(negedge clk);
          chk(done == 0, "R9 mid pass", done, 0);
        end
        @(negedge clk);
        chk(done == 1, "R9 done due", done, 1);
        check_out(cur, "R9 last pass");
        chk(busy == 0, "R9 busy falls", busy, 0);
        break;
      end
    end
    @(negedge clk);
    chk(busy == 0 && done == 0, "R9 stopped", {busy, done}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule